// File: doc/BRIEF.md
# Lite memory-mapped UART

This block is a small asynchronous serial port that sits behind a simple word-addressed register bus. Software queues characters for the line by writing a data register and collects arrived characters by reading another. It learns the state of both queues, the current interrupt enable and three sticky error conditions from a status word. A control register gives one-shot queue flushes per direction and the interrupt enable. Baud divisor, character width and parity mode are fixed by parameters, and nothing about the line format can change at run time.

Each direction owns a first-in first-out queue. The transmitter drains its queue into a shift register and sends start, data, parity and stop bits. The receiver oversamples the line sixteen times per bit, confirms a start bit at its middle and takes each later bit at its centre. It also flags bad stop bits, parity mismatches and characters lost to a full queue. A single interrupt line pulses for one clock when the receive queue gains its first entry or the transmit queue runs dry.

The bus selects a register with a two-bit word index, which is the byte offset shifted right by two: index 0 (offset 0x00) reads received data, index 1 (0x04) writes transmit data, index 2 (0x08) reads status and index 3 (0x0C) writes control. Reads return the value combinationally in the cycle the read strobe is high, and any side effect of the read takes place at the closing clock edge.

Top module: `lite_uart`

## Requirements
- R1: A write to word index 1 queues its byte for transmission. A read of word index 0 returns the oldest received byte in bits 7:0 and removes it, so bytes come out in arrival order.
- R2: Status bits 7:0 read as {parity error, frame error, overrun, interrupt enable, tx queue full, tx queue empty, rx queue full, rx data valid}, with bit 0 the rightmost. Status reads 0x04 after reset.
- R3: A control write loads bit 4 into the interrupt enable, which status bit 4 mirrors. A control write with bit 4 clear disables interrupts. Neither write changes the contents of either queue.
- R4: Control bit 0 empties the transmit queue and control bit 1 empties the receive queue. Both act once per write and need no write of 0 afterwards. A character already in the transmit shifter finishes.
- R5: Each queue holds FIFO_DEPTH (16) bytes. Status bit 3 is set once 16 bytes wait in the transmit queue, and a write while it is full is ignored.
- R6: A character that completes while the receive queue is full is dropped and sets status bit 5. The 16 stored bytes are kept.
- R7: A stop bit sampled low sets status bit 6 and discards that character. The receiver then waits for the line to return high before it looks for a new start bit.
- R8: A character whose parity bit fails the check (even parity by default) is still stored and sets status bit 7.
- R9: Status bits 5, 6 and 7 clear when the status register is read, unless a new error arrives in the same cycle.
- R10: With interrupts enabled, irq is high for exactly one cycle when the receive queue goes from empty to non-empty. With interrupts disabled it stays low.
- R11: With interrupts enabled, irq pulses for one cycle when the transmit queue becomes empty after holding data.
- R12: The transmit line idles high. Each character is sent as a low start bit, data LSB first, the parity bit and one high stop bit. Every bit lasts 16*TICK_DIV clocks.
- R13: A low level on the receive line is taken as a start bit only if it is still low at the middle of the bit. A shorter low pulse produces no character and no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busSel | input | 2 | Register word index (byte offset / 4) |
| busWrData | input | 8 | Write data, low byte of the bus word |
| busRdData | output | 32 | Read data, upper 24 bits zero |
| irq | output | 1 | Interrupt pulse |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
On every cycle the embedded properties check several things. A flush leaves its queue empty on the next cycle, and a push into a full queue moves nothing. A dropped character leaves the receive queue full. The interrupt enable takes the written bit. A status read clears the sticky errors. An interrupt pulse only follows a change in a queue-state flag, the line is high as the shifter goes idle, and the receiver enters its data phase only after a confirmed low start sample. Only the bench scenarios can show the rest: the bit-accurate shape and timing of a transmitted frame, the byte order through the queues, which character is lost on overrun, that a frame error discards and a parity error keeps, that a short glitch is ignored, and the exact number of interrupt pulses per event.

// File: rtl/lite_uart_pkg.sv
package lite_uart_pkg;

  // Register word index (byte offset >> 2)
  typedef enum logic [1:0] {
    SEL_RXDATA = 2'd0,
    SEL_TXDATA = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_CTRL   = 2'd3
  } reg_sel_e;

  // Control bit positions
  localparam int unsigned CTL_TXCLR = 0;
  localparam int unsigned CTL_RXCLR = 1;
  localparam int unsigned CTL_IE    = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic txFlush;
    logic rxFlush;
  } uart_strobe_t;

  // Flags and events from datapath to control
  typedef struct packed {
    logic rxValid;
    logic rxFull;
    logic txEmpty;
    logic txFull;
    logic evtOverrun;
    logic evtFrame;
    logic evtParity;
  } uart_flags_t;

endpackage

// File: rtl/lite_uart_fifo.sv
module lite_uart_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic         pop,
  input  logic         flush,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdData = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  // R4: a flush leaves the queue empty
  a_r4_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> empty);

  // R5: pushing into a full queue changes nothing
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop && !flush) |=> (full && $stable(wrPtr)));

endmodule

// File: rtl/lite_uart_dp.sv
module lite_uart_dp
  import lite_uart_pkg::*;
#(
  parameter int unsigned TICK_DIV   = 27,
  parameter int unsigned DATA_BITS  = 8,
  parameter int unsigned PARITY     = 1,   // 0 none, 1 even, 2 odd
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  uart_strobe_t         strobe,
  input  logic [DATA_BITS-1:0] txByte,
  output logic [DATA_BITS-1:0] rxHead,
  output uart_flags_t          flags,
  input  logic                 rxd,
  output logic                 txd
);
  localparam int unsigned PB         = (PARITY != 0) ? 1 : 0;
  localparam int unsigned RXB        = DATA_BITS + PB;        // bits after start, before stop
  localparam int unsigned FRAME_BITS = RXB + 2;
  localparam int unsigned BIT_CLKS   = 16 * TICK_DIV;
  localparam int unsigned TDW        = $clog2(TICK_DIV + 1);
  localparam int unsigned BCW        = $clog2(BIT_CLKS);
  localparam int unsigned FW         = $clog2(FRAME_BITS + 1);
  localparam int unsigned IXW        = $clog2(RXB + 1);
  localparam logic        ODD_PAR    = (PARITY == 2);

  // ---------------- transmit path ----------------
  logic [DATA_BITS-1:0]  txHead;
  logic                  txEmpty, txFull, txBusy, txLoad;
  logic [FRAME_BITS-1:0] txSh, loadFrame;
  logic [BCW-1:0]        txClk;
  logic [FW-1:0]         bitsLeft;

  assign txLoad = !txBusy && !txEmpty;

  lite_uart_fifo #(.W(DATA_BITS), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk, .rstN, .push(strobe.txPush), .pop(txLoad), .flush(strobe.txFlush),
    .wrData(txByte), .rdData(txHead), .empty(txEmpty), .full(txFull));

  generate
    if (PB != 0) begin : g_txpar
      assign loadFrame = {1'b1, (^txHead) ^ ODD_PAR, txHead, 1'b0};
    end else begin : g_txnopar
      assign loadFrame = {1'b1, txHead, 1'b0};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy   <= 1'b0;
      txSh     <= '1;
      txClk    <= '0;
      bitsLeft <= '0;
    end else if (txLoad) begin
      txBusy   <= 1'b1;
      txSh     <= loadFrame;
      txClk    <= '0;
      bitsLeft <= FW'(FRAME_BITS);
    end else if (txBusy) begin
      if (txClk == BCW'(BIT_CLKS - 1)) begin
        txClk    <= '0;
        txSh     <= {1'b1, txSh[FRAME_BITS-1:1]};
        bitsLeft <= bitsLeft - 1'b1;
        if (bitsLeft == FW'(1)) txBusy <= 1'b0;
      end else begin
        txClk <= txClk + 1'b1;
      end
    end
  end

  assign txd = txBusy ? txSh[0] : 1'b1;

  // ---------------- receive path ----------------
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_HOLD} rx_state_e;

  rx_state_e            rxState;
  logic [TDW-1:0]       tickCnt;
  logic                 tick, rxMeta, rxS;
  logic [3:0]           smpCnt;
  logic [IXW-1:0]       rxIdx;
  logic [RXB-1:0]       rxSh;
  logic                 rxDoneQ, frameQ, parQ, parErrNow;
  logic [DATA_BITS-1:0] rxData;
  logic                 rxEmpty, rxFull, rxPush;

  assign tick = (tickCnt == TDW'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
      rxMeta  <= 1'b1;
      rxS     <= 1'b1;
    end else begin
      tickCnt <= tick ? '0 : tickCnt + 1'b1;
      rxMeta  <= rxd;
      rxS     <= rxMeta;
    end
  end

  generate
    if (PB != 0) begin : g_rxpar
      assign parErrNow = rxSh[DATA_BITS] != ((^rxSh[DATA_BITS-1:0]) ^ ODD_PAR);
    end else begin : g_rxnopar
      assign parErrNow = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      smpCnt  <= '0;
      rxIdx   <= '0;
      rxSh    <= '0;
      rxDoneQ <= 1'b0;
      frameQ  <= 1'b0;
      parQ    <= 1'b0;
      rxData  <= '0;
    end else begin
      rxDoneQ <= 1'b0;
      unique case (rxState)
        RX_IDLE: if (!rxS) begin
          rxState <= RX_START;
          smpCnt  <= '0;
        end
        RX_START: if (tick) begin
          if (smpCnt == 4'd7) begin
            smpCnt  <= '0;
            rxIdx   <= '0;
            rxState <= rxS ? RX_IDLE : RX_BITS;
          end else smpCnt <= smpCnt + 1'b1;
        end
        RX_BITS: if (tick) begin
          if (smpCnt == 4'd15) begin
            smpCnt <= '0;
            if (rxIdx == IXW'(RXB)) begin
              rxDoneQ <= 1'b1;
              frameQ  <= !rxS;
              parQ    <= parErrNow;
              rxData  <= rxSh[DATA_BITS-1:0];
              rxState <= RX_HOLD;
            end else begin
              rxSh  <= {rxS, rxSh[RXB-1:1]};
              rxIdx <= rxIdx + 1'b1;
            end
          end else smpCnt <= smpCnt + 1'b1;
        end
        RX_HOLD: if (rxS) rxState <= RX_IDLE;
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  assign rxPush = rxDoneQ && !frameQ;

  lite_uart_fifo #(.W(DATA_BITS), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk, .rstN, .push(rxPush), .pop(strobe.rxPop), .flush(strobe.rxFlush),
    .wrData(rxData), .rdData(rxHead), .empty(rxEmpty), .full(rxFull));

  always_comb begin
    flags.rxValid    = !rxEmpty;
    flags.rxFull     = rxFull;
    flags.txEmpty    = txEmpty;
    flags.txFull     = txFull;
    flags.evtOverrun = rxPush && rxFull;
    flags.evtFrame   = rxDoneQ && frameQ;
    flags.evtParity  = rxPush && parQ;
  end

  // R6: a dropped character leaves the full queue as it was
  a_r6_overrun_keeps_full: assert property (@(posedge clk) disable iff (!rstN)
    (flags.evtOverrun && !strobe.rxPop && !strobe.rxFlush) |=> rxFull);

  // R12: the last bit before the shifter goes idle is a high stop bit
  a_r12_stop_high: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txBusy) |-> $past(txd));

  // R13: data phase only after a low sample at mid start bit
  a_r13_start_confirmed: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_BITS && $past(rxState) == RX_START) |-> !$past(rxS));

endmodule

// File: rtl/lite_uart_ctrl.sv
module lite_uart_ctrl
  import lite_uart_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busRd,
  input  logic                 busWr,
  input  logic [1:0]           busSel,
  input  logic [7:0]           busWrData,
  input  logic [DATA_BITS-1:0] rxHead,
  input  uart_flags_t          flags,
  output uart_strobe_t         strobe,
  output logic [DATA_BITS-1:0] txByte,
  output logic [31:0]          busRdData,
  output logic                 irq
);
  reg_sel_e   sel;
  logic       ctrlWr, statusRd;
  logic       ie, ovrF, frmF, parF, rxEmptyQ, txEmptyQ;
  logic [7:0] statusByte;

  assign sel      = reg_sel_e'(busSel);
  assign ctrlWr   = busWr && (sel == SEL_CTRL);
  assign statusRd = busRd && (sel == SEL_STATUS);
  assign txByte   = busWrData[DATA_BITS-1:0];

  always_comb begin
    strobe.txPush  = busWr && (sel == SEL_TXDATA);
    strobe.rxPop   = busRd && (sel == SEL_RXDATA);
    strobe.txFlush = ctrlWr && busWrData[CTL_TXCLR];
    strobe.rxFlush = ctrlWr && busWrData[CTL_RXCLR];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ie       <= 1'b0;
      ovrF     <= 1'b0;
      frmF     <= 1'b0;
      parF     <= 1'b0;
      rxEmptyQ <= 1'b1;
      txEmptyQ <= 1'b1;
    end else begin
      if (ctrlWr) ie <= busWrData[CTL_IE];
      ovrF     <= flags.evtOverrun | (ovrF & ~statusRd);
      frmF     <= flags.evtFrame   | (frmF & ~statusRd);
      parF     <= flags.evtParity  | (parF & ~statusRd);
      rxEmptyQ <= !flags.rxValid;
      txEmptyQ <= flags.txEmpty;
    end
  end

  assign statusByte = {parF, frmF, ovrF, ie,
                       flags.txFull, flags.txEmpty, flags.rxFull, flags.rxValid};

  always_comb begin
    unique case (sel)
      SEL_RXDATA: busRdData = 32'(rxHead);
      SEL_STATUS: busRdData = 32'(statusByte);
      default:    busRdData = '0;
    endcase
  end

  assign irq = ie & ((rxEmptyQ & flags.rxValid) | (~txEmptyQ & flags.txEmpty));

  // R3: interrupt enable takes the written bit
  a_r3_ie_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (ie == $past(busWrData[CTL_IE])));

  // R9: a status read with no new error clears all sticky flags
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !flags.evtOverrun && !flags.evtFrame && !flags.evtParity)
      |=> (!ovrF && !frmF && !parF));

  // R10 / R11: a pulse only follows a change of a queue-state flag
  a_r10_irq_on_change: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((flags.rxValid != $past(flags.rxValid)) ||
             (flags.txEmpty != $past(flags.txEmpty))));

endmodule

// File: rtl/lite_uart.sv
module lite_uart
  import lite_uart_pkg::*;
#(
  parameter int unsigned TICK_DIV   = 27,
  parameter int unsigned DATA_BITS  = 8,
  parameter int unsigned PARITY     = 1,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busRd,
  input  logic        busWr,
  input  logic [1:0]  busSel,
  input  logic [7:0]  busWrData,
  output logic [31:0] busRdData,
  output logic        irq,
  input  logic        rxd,
  output logic        txd
);
  uart_strobe_t         strobe;
  uart_flags_t          flags;
  logic [DATA_BITS-1:0] txByte, rxHead;

  lite_uart_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk, .rstN, .busRd, .busWr, .busSel, .busWrData,
    .rxHead, .flags, .strobe, .txByte, .busRdData, .irq);

  lite_uart_dp #(.TICK_DIV(TICK_DIV), .DATA_BITS(DATA_BITS),
                 .PARITY(PARITY), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk, .rstN, .strobe, .txByte, .rxHead, .flags, .rxd, .txd);

endmodule

// File: tb/lite_uart_bench.sv
module lite_uart_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int BIT_CYC    = 16 * TICK_DIV;
  localparam int BIT_T      = BIT_CYC * CLK_PERIOD;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        busRd = 1'b0, busWr = 1'b0;
  logic [1:0]  busSel = 2'd0;
  logic [7:0]  busWrData = 8'd0;
  logic [31:0] busRdData;
  logic        irq, txd, rxd;
  logic        loopOn = 1'b0, drvLine = 1'b1;

  int checks = 0, fails = 0, irqCount = 0, txN = 0;
  bit finished = 1'b0;
  logic [7:0] txLog [128];
  bit         txOk  [128];

  assign rxd = loopOn ? txd : drvLine;

  lite_uart #(.TICK_DIV(TICK_DIV), .DATA_BITS(8), .PARITY(1), .FIFO_DEPTH(16)) u_lite_uart (
    .clk, .rstN, .busRd, .busWr, .busSel, .busWrData, .busRdData, .irq, .rxd, .txd);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (irq === 1'b1) irqCount++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); busSel = sel; busWrData = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output int val);
    @(negedge clk); busSel = sel; busRd = 1'b1;
    #1 val = int'(busRdData);
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic holdBit(input logic v);
    drvLine = v;
    repeat (BIT_CYC) @(negedge clk);
  endtask

  // serial driver: even parity, optional bad parity / low stop
  task automatic sendLine(input logic [7:0] b, input bit badPar, input bit badStop);
    holdBit(1'b0);
    for (int i = 0; i < 8; i++) holdBit(b[i]);
    holdBit((^b) ^ badPar);
    holdBit(!badStop);
    if (badStop) holdBit(1'b1);
    drvLine = 1'b1;
  endtask

  // background decoder of the transmit line
  initial begin
    forever begin
      logic [7:0] b;
      logic s0, p, st;
      @(negedge txd);
      #(BIT_T/2 + 2) s0 = txd;
      for (int i = 0; i < 8; i++) begin #(BIT_T) b[i] = txd; end
      #(BIT_T) p = txd;
      #(BIT_T) st = txd;
      if (txN < 128) begin
        txLog[txN] = b;
        txOk[txN]  = (s0 == 1'b0) && (p == ^b) && (st == 1'b1);
      end
      txN++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int st, d, base, n;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    regRead(2, st); chk("R2 reset status", st, 32'h04);
    chk("R10 irq low after reset", int'(irq), 0);
    chk("R12 line idle high", int'(txd), 1);

    // loopback sweep: frame shape and byte path
    loopOn = 1'b1;
    for (int i = 0; i < 40; i++) begin
      v = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'((i * 53 + 17) % 256);
      n = txN;
      regWrite(1, v);
      wait (txN == n + 1);
      repeat (BIT_CYC) @(negedge clk);
      chk("R12 frame format", int'(txOk[n]), 1);
      chk("R12 sent byte", int'(txLog[n]), int'(v));
      regRead(2, st); chk("R2 rx valid set", st & 1, 1);
      regRead(0, d);  chk("R1 received byte", d, int'(v));
      regRead(2, st); chk("R2 rx valid clear", st & 1, 0);
    end
    loopOn = 1'b0;

    // fill receive queue, then overrun
    for (int i = 0; i < 16; i++) sendLine(8'(i * 17 + 3), 1'b0, 1'b0);
    regRead(2, st); chk("R5 rx full status", st, 32'h07);
    sendLine(8'h5A, 1'b0, 1'b0);
    regRead(2, st); chk("R6 overrun flag", st, 32'h27);
    regRead(2, st); chk("R9 overrun cleared", st, 32'h07);
    for (int i = 0; i < 16; i++) begin
      regRead(0, d); chk("R6 stored order kept", d, (i * 17 + 3) % 256);
    end
    regRead(2, st); chk("R6 dropped byte absent", st, 32'h04);

    // parity error: kept and flagged
    sendLine(8'hC3, 1'b1, 1'b0);
    regRead(2, st); chk("R8 parity flag", st, 32'h85);
    regRead(0, d);  chk("R8 byte kept", d, 32'hC3);
    regRead(2, st); chk("R9 parity cleared", st, 32'h04);

    // framing error: discarded and flagged
    sendLine(8'h3C, 1'b0, 1'b1);
    regRead(2, st); chk("R7 frame flag, no data", st, 32'h44);
    regRead(2, st); chk("R9 frame cleared", st, 32'h04);

    // short glitch
    @(negedge clk); drvLine = 1'b0;
    repeat (4) @(negedge clk); drvLine = 1'b1;
    repeat (2 * BIT_CYC) @(negedge clk);
    regRead(2, st); chk("R13 glitch ignored", st, 32'h04);

    // receive flush
    sendLine(8'h11, 1'b0, 1'b0); sendLine(8'h22, 1'b0, 1'b0); sendLine(8'h33, 1'b0, 1'b0);
    regRead(2, st); chk("R4 rx holds data", st, 32'h05);
    regWrite(3, 8'h02);
    regRead(2, st); chk("R4 rx flushed", st, 32'h04);
    sendLine(8'h44, 1'b0, 1'b0);
    regRead(0, d);  chk("R4 rx usable after flush", d, 32'h44);

    // interrupt enable does not disturb queues
    sendLine(8'h55, 1'b0, 1'b0); sendLine(8'h66, 1'b0, 1'b0);
    regWrite(3, 8'h10);
    regRead(2, st); chk("R3 ie visible", st, 32'h15);
    regRead(0, d);  chk("R3 first byte intact", d, 32'h55);
    regRead(0, d);  chk("R3 second byte intact", d, 32'h66);
    regWrite(3, 8'h00);
    regRead(2, st); chk("R3 ie cleared", st, 32'h04);

    // receive interrupt
    regWrite(3, 8'h10);
    base = irqCount;
    sendLine(8'h77, 1'b0, 1'b0);
    chk("R10 one pulse on first byte", irqCount - base, 1);
    sendLine(8'h78, 1'b0, 1'b0);
    chk("R10 no pulse when already non-empty", irqCount - base, 1);
    regRead(0, d); regRead(0, d);
    regWrite(3, 8'h00);
    sendLine(8'h79, 1'b0, 1'b0);
    chk("R10 no pulse when disabled", irqCount - base, 1);
    regRead(0, d);

    // transmit-drained interrupt
    regWrite(3, 8'h10);
    base = irqCount;
    regWrite(1, 8'h81);
    repeat (4) @(negedge clk);
    chk("R11 pulse on tx drain", irqCount - base, 1);
    repeat (13 * BIT_CYC) @(negedge clk);
    chk("R11 single pulse per drain", irqCount - base, 1);
    regWrite(3, 8'h00);

    // transmit queue full, extra write ignored
    n = txN;
    for (int i = 0; i < 17; i++) regWrite(1, 8'(8'h90 + i));
    regRead(2, st); chk("R5 tx full status", st, 32'h08);
    regWrite(1, 8'hEE);
    repeat (18 * 11 * BIT_CYC) @(negedge clk);
    chk("R5 frames sent", txN - n, 17);
    for (int i = 0; i < 17; i++) chk("R5 tx order", int'(txLog[n + i]), 32'h90 + i);

    // transmit flush
    n = txN;
    for (int i = 0; i < 5; i++) regWrite(1, 8'(8'hD0 + i));
    regWrite(3, 8'h01);
    regRead(2, st); chk("R4 tx flushed", st, 32'h04);
    repeat (14 * BIT_CYC) @(negedge clk);
    chk("R4 only shifter byte sent", txN - n, 1);
    chk("R4 shifter byte", int'(txLog[n]), 32'hD0);
    regWrite(1, 8'hE7);
    repeat (13 * BIT_CYC) @(negedge clk);
    chk("R4 tx usable after flush", txN - n, 2);
    chk("R4 post-flush byte", int'(txLog[n + 1]), 32'hE7);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule